// File: doc/BRIEF.md
# Two-Channel Burst DMA Sequencer

This block runs two independent DMA channels that copy words from a far bus to a local destination bus in bursts of at most eight words. Software programs each channel through a small register file: a source address, a destination address and a length word. The top bit of the length word is the run flag. Once a channel runs, the sequencer must take sole use of a shared bridge before each burst. It does this in two phases. First it answers new local-side slave attempts with retry and waits for outbound traffic to drain. Then it stops serving inbound far-bus requests and waits for inbound traffic to drain. Only then does it push a read request into a request FIFO and stream the returned words into destination writes.

After every burst the channel's address and length counters advance. The sequencer may then keep the bridge for the next burst. It gives the bridge up when a foreign access turned up while it held the bridge, or when the other channel is waiting to run. In either case it acquires the bridge again for the next burst, and contending channels take turns. When a channel finishes, its run flag drops and a sticky done flag rises. The done flag raises the interrupt if that channel's interrupt enable is set.

Top module: `dma2_seq`

## Requirements
- R1: A channel starts only when a length word is written with bit 31 set (length in bits [LW-1:0]). Writing a length with bit 31 clear starts nothing.
- R2: While `out_pending` is high during acquisition, `slv_retry` is high, `in_hold` is low and no request is issued.
- R3: `in_hold` rises only after `slv_retry` is already high and `out_pending` has been seen low. While `in_pending` is high, no request is issued.
- R4: Each request carries the channel's source address and a word count of min(remaining, 8). The returned words go to consecutive destination addresses starting at the channel's destination address, with data unchanged. A request is held stable until accepted.
- R5: After a burst's last destination write, source and destination advance by the burst size and the remaining length drops by it.
- R6: A local slave attempt (`slv_req`) or an inbound request (`in_req`) seen while the bridge is held makes the channel drop `slv_retry` and `in_hold` for at least one cycle after the current burst. The channel then reacquires the bridge and continues.
- R7: When both channels run, bursts alternate between them, starting with channel 0 after reset.
- R8: At completion the run flag (bit 31 of the length word) clears and done bit c of the status word (address 3) sets. A zero length completes without acquiring the bridge.
- R9: Status bits [1:0] are done flags, cleared by writing 1. Bits [3:2] are interrupt enables. `irq` is a registered OR of done AND enable for each channel.
- R10: Writes to a channel's source, destination or length register while it runs are ignored.
- R11: After reset all registers read zero and `slv_retry`, `in_hold`, `rq_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (c*4+0 src, +1 dst, +2 length; 3 status) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data for `reg_addr` |
| slv_req | input | 1 | Local-side slave access attempt |
| slv_retry | output | 1 | Local slave attempts are being retried |
| out_pending | input | 1 | Outbound bridge accesses still in flight |
| in_req | input | 1 | Inbound far-bus access request |
| in_hold | output | 1 | Inbound servicing stopped |
| in_pending | input | 1 | Inbound accesses still in flight |
| rq_valid | output | 1 | Read request valid |
| rq_ready | input | 1 | Request FIFO accepts |
| rq_addr | output | AW | Read request source address |
| rq_len | output | BW | Read request word count |
| rx_valid | input | 1 | Receive FIFO has a word |
| rx_ready | output | 1 | Receive FIFO pop |
| rx_data | input | DW | Receive FIFO word |
| wr_valid | output | 1 | Destination write valid |
| wr_ready | input | 1 | Destination accepts write |
| wr_addr | output | AW | Destination word address |
| wr_data | output | DW | Destination write data |
| irq | output | 1 | Interrupt |

## Verification
The hardest case to reach is a release in the middle of a transfer. A foreign access has to arrive while a burst is in flight, and the bench must see the sequencer let go of the bridge between two bursts of the same channel. The bench watches the destination write count and pulses `slv_req` or `in_req` partway through the first burst. It then counts the falling edges of `slv_retry` and expects exactly one extra release. Alternation is forced after a fresh reset by starting both channels back to back and recording which channel owns each accepted request.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ_OUT,
    ST_ACQ_IN,
    ST_REQ,
    ST_DATA,
    ST_UPD
  } eng_state_t;
endpackage

// File: rtl/dma2_chan_regs.sv
module dma2_chan_regs #(
  parameter int AW = 16,
  parameter int LW = 12,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic          wr_len,
  input  logic [AW-1:0] wdata_addr,
  input  logic [LW-1:0] wdata_len,
  input  logic          wdata_run,
  input  logic          upd,
  input  logic [BW-1:0] upd_n,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [LW-1:0] len_o,
  output logic          run_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      src_o <= '0;
      dst_o <= '0;
      len_o <= '0;
      run_o <= 1'b0;
    end else if (upd) begin
      src_o <= src_o + AW'(upd_n);
      dst_o <= dst_o + AW'(upd_n);
      len_o <= len_o - LW'(upd_n);
      if (len_o == LW'(upd_n)) run_o <= 1'b0;
    end else if (!run_o) begin
      if (wr_src) src_o <= wdata_addr;
      if (wr_dst) dst_o <= wdata_addr;
      if (wr_len) begin
        len_o <= wdata_len;
        run_o <= wdata_run;
      end
    end
  end

  // R10: a running channel's registers move only through burst updates
  assert_locked_R10: assert property (@(posedge clk) disable iff (rst)
    run_o && !upd |=> $stable(src_o) && $stable(dst_o) && $stable(len_o));
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb (
  input  logic [1:0] run,
  input  logic       last,
  output logic       any,
  output logic       pick
);
  always_comb begin
    any  = |run;
    pick = (run == 2'b11) ? ~last : run[1];
  end
endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
  import dma2_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LW    = 12,
  parameter int BURST = 8,
  parameter int BW    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          run,
  input  logic [1:0][AW-1:0]  src_i,
  input  logic [1:0][AW-1:0]  dst_i,
  input  logic [1:0][LW-1:0]  len_i,
  input  logic                slv_req,
  input  logic                in_req,
  input  logic                out_pending,
  input  logic                in_pending,
  output logic                slv_retry,
  output logic                in_hold,
  output logic                rq_valid,
  input  logic                rq_ready,
  output logic [AW-1:0]       rq_addr,
  output logic [BW-1:0]       rq_len,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [DW-1:0]       rx_data,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [AW-1:0]       wr_addr,
  output logic [DW-1:0]       wr_data,
  output logic                upd,
  output logic                upd_ch,
  output logic [BW-1:0]       upd_n,
  output logic [1:0]          cmpl
);
  eng_state_t    state;
  logic          cur, last, foreign;
  logic [BW-1:0] cnt, blen;
  logic          arb_any, arb_pick;
  logic [LW-1:0] rem_after;
  logic          finish;

  function automatic logic [BW-1:0] burst_of(input logic [LW-1:0] l);
    if (l >= LW'(BURST)) return BW'(BURST);
    else return l[BW-1:0];
  endfunction

  dma2_arb u_arb (.run(run), .last(last), .any(arb_any), .pick(arb_pick));

  always_comb begin
    rem_after = len_i[cur] - LW'(blen);
    finish    = (len_i[cur] == LW'(blen));
    rq_valid  = (state == ST_REQ);
    rq_addr   = src_i[cur];
    rq_len    = blen;
    rx_ready  = (state == ST_DATA) && wr_ready;
    wr_valid  = (state == ST_DATA) && rx_valid;
    wr_addr   = dst_i[cur] + AW'(cnt);
    wr_data   = rx_data;
    upd       = (state == ST_UPD);
    upd_ch    = cur;
    upd_n     = blen;
    cmpl      = '0;
    cmpl[cur] = upd && finish;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur       <= 1'b0;
      last      <= 1'b1;
      foreign   <= 1'b0;
      cnt       <= '0;
      blen      <= '0;
      slv_retry <= 1'b0;
      in_hold   <= 1'b0;
    end else begin
      if (state != ST_IDLE && (slv_req || in_req)) foreign <= 1'b1;
      case (state)
        ST_IDLE: begin
          foreign <= 1'b0;
          if (arb_any) begin
            cur  <= arb_pick;
            last <= arb_pick;
            blen <= burst_of(len_i[arb_pick]);
            if (len_i[arb_pick] == '0) state <= ST_UPD;
            else begin
              state     <= ST_ACQ_OUT;
              slv_retry <= 1'b1;
            end
          end
        end
        ST_ACQ_OUT: if (!out_pending) begin
          state   <= ST_ACQ_IN;
          in_hold <= 1'b1;
        end
        ST_ACQ_IN: if (!in_pending) state <= ST_REQ;
        ST_REQ: if (rq_ready) begin
          state <= ST_DATA;
          cnt   <= '0;
        end
        ST_DATA: if (rx_valid && wr_ready) begin
          cnt <= cnt + BW'(1);
          if (cnt == blen - BW'(1)) state <= ST_UPD;
        end
        ST_UPD: begin
          if (finish || foreign || slv_req || in_req || run[~cur]) begin
            state     <= ST_IDLE;
            slv_retry <= 1'b0;
            in_hold   <= 1'b0;
          end else begin
            blen  <= burst_of(rem_after);
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: inbound hold follows local retry and a drained outbound path
  assert_hold_order_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(in_hold) |-> $past(slv_retry) && !$past(out_pending));
  // R2: no request unless both acquisition phases are in force
  assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> slv_retry && in_hold);
  // R4: a waiting request stays stable
  assert_req_stable_R4: assert property (@(posedge clk) disable iff (rst)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_addr) && $stable(rq_len));
  // R4: burst size bounded
  assert_burst_bound_R4: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> (rq_len != '0) && (rq_len <= BW'(BURST)));
endmodule

// File: rtl/dma2_seq.sv
module dma2_seq #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LW    = 12,
  parameter int BURST = 8,
  localparam int BW   = $clog2(BURST + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          slv_req,
  output logic          slv_retry,
  input  logic          out_pending,
  input  logic          in_req,
  output logic          in_hold,
  input  logic          in_pending,
  output logic          rq_valid,
  input  logic          rq_ready,
  output logic [AW-1:0] rq_addr,
  output logic [BW-1:0] rq_len,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          irq
);
  localparam logic [2:0] A_STAT = 3'd3;

  logic [1:0][AW-1:0] src_a, dst_a;
  logic [1:0][LW-1:0] len_a;
  logic [1:0]         run_a;
  logic [1:0]         done, ien, cmpl;
  logic               upd, upd_ch;
  logic [BW-1:0]      upd_n;
  logic               wr_stat;

  assign wr_stat = reg_wr && (reg_addr == A_STAT);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    dma2_chan_regs #(.AW(AW), .LW(LW), .BW(BW)) u_regs (
      .clk(clk), .rst(rst),
      .wr_src(reg_wr && reg_addr == 3'(4*c)),
      .wr_dst(reg_wr && reg_addr == 3'(4*c+1)),
      .wr_len(reg_wr && reg_addr == 3'(4*c+2)),
      .wdata_addr(reg_wdata[AW-1:0]),
      .wdata_len(reg_wdata[LW-1:0]),
      .wdata_run(reg_wdata[DW-1]),
      .upd(upd && (upd_ch == 1'(c))),
      .upd_n(upd_n),
      .src_o(src_a[c]), .dst_o(dst_a[c]), .len_o(len_a[c]), .run_o(run_a[c])
    );
  end

  dma2_engine #(.AW(AW), .DW(DW), .LW(LW), .BURST(BURST), .BW(BW)) u_eng (
    .clk(clk), .rst(rst), .run(run_a),
    .src_i(src_a), .dst_i(dst_a), .len_i(len_a),
    .slv_req(slv_req), .in_req(in_req),
    .out_pending(out_pending), .in_pending(in_pending),
    .slv_retry(slv_retry), .in_hold(in_hold),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr), .rq_len(rq_len),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd(upd), .upd_ch(upd_ch), .upd_n(upd_n), .cmpl(cmpl)
  );

  function automatic logic [DW-1:0] len_word(input logic r, input logic [LW-1:0] l);
    logic [DW-1:0] w;
    w = '0;
    w[LW-1:0] = l;
    w[DW-1] = r;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= '0;
      ien       <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_stat) ien <= reg_wdata[3:2];
      done <= (done & ~(wr_stat ? reg_wdata[1:0] : 2'b00)) | cmpl;
      irq  <= |(done & ien);
      case (reg_addr)
        3'd0:    reg_rdata <= DW'(src_a[0]);
        3'd1:    reg_rdata <= DW'(dst_a[0]);
        3'd2:    reg_rdata <= len_word(run_a[0], len_a[0]);
        3'd3:    reg_rdata <= DW'({ien, done});
        3'd4:    reg_rdata <= DW'(src_a[1]);
        3'd5:    reg_rdata <= DW'(dst_a[1]);
        3'd6:    reg_rdata <= len_word(run_a[1], len_a[1]);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R8: completion drops the run flag
  assert_run_clear_R8: assert property (@(posedge clk) disable iff (rst)
    cmpl[0] |=> !run_a[0]);
  assert_run_clear1_R8: assert property (@(posedge clk) disable iff (rst)
    cmpl[1] |=> !run_a[1]);
  // R9: an enabled completion reaches the interrupt
  assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
    cmpl[0] && ien[0] && !wr_stat |=> ##1 irq);
endmodule

// File: tb/dma2_seq_test.sv
module dma2_seq_test;
  logic        clk = 0, rst = 1;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        slv_req = 0, slv_retry, out_pending = 0, in_req = 0, in_hold, in_pending = 0;
  logic        rq_valid, rq_ready = 0;
  logic [15:0] rq_addr;
  logic [3:0]  rq_len;
  logic        rx_valid = 0, rx_ready;
  logic [31:0] rx_data = 0;
  logic        wr_valid, wr_ready = 0;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        irq;

  dma2_seq uut (.*);

  always #5 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0, stream_err = 0, falls = 0, nseq = 0;
  int seq[32];
  int rem[2], nwr[2];
  logic [15:0] sbase[2], dbase[2], exp_wa[2];
  bit rq_gate = 1, prev_retry = 0;
  int pend = 0;
  logic [15:0] rd_ptr = 0;
  bit s_rq = 0, s_rx = 0, s_wr = 0;
  logic [15:0] s_rqa, s_wa;
  logic [3:0] s_rql;
  logic [31:0] s_wd;

  // bus-side responder
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (s_rq) begin
        int ch, e;
        ch = (s_rqa >= 16'h2000) ? 1 : 0;
        e = (rem[ch] > 8) ? 8 : rem[ch];
        if (int'(s_rql) != e || s_rqa != sbase[ch] + 16'(rem0_done(ch))) begin
          stream_err++;
          $display("mismatch request ch%0d len=%0d exp=%0d", ch, s_rql, e);
        end
        rem[ch] -= int'(s_rql);
        if (nseq < 32) seq[nseq] = ch;
        nseq++;
        pend = int'(s_rql);
        rd_ptr = s_rqa;
      end
      if (s_rx) begin pend--; rd_ptr++; end
      if (s_wr) begin
        int ch;
        ch = (s_wa >= 16'h8000) ? 1 : 0;
        if (s_wa != exp_wa[ch] || s_wd != {16'hBEEF, sbase[ch] + (s_wa - dbase[ch])}) begin
          stream_err++;
          $display("mismatch write addr=%h data=%h", s_wa, s_wd);
        end
        exp_wa[ch]++;
        nwr[ch]++;
      end
      if (prev_retry && !slv_retry) falls++;
      prev_retry = slv_retry;
      rq_ready = rq_gate && (cyc % 3 != 0);
      rx_valid = (pend > 0) && (cyc % 4 != 3);
      rx_data  = {16'hBEEF, rd_ptr};
      wr_ready = (cyc % 5 != 4);
      #1;
      s_rq = rq_valid && rq_ready; s_rqa = rq_addr; s_rql = rq_len;
      s_rx = rx_valid && rx_ready;
      s_wr = wr_valid && wr_ready; s_wa = wr_addr; s_wd = wr_data;
    end
  end

  int total_len[2];
  function automatic int rem0_done(input int ch);
    return total_len[ch] - rem[ch];
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R1 watchdog expired act=hung exp=finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #2; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #2; reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); #2; reg_addr = a;
    @(negedge clk); #2; d = reg_rdata;
  endtask

  task automatic setup(input int c, input logic [15:0] s, input logic [15:0] d, input int len);
    sbase[c] = s; dbase[c] = d; exp_wa[c] = d; rem[c] = len; total_len[c] = len; nwr[c] = 0;
    wr_reg(3'(4*c), {16'h0, s});
    wr_reg(3'(4*c+1), {16'h0, d});
  endtask

  task automatic arm(input int c, input int len);
    wr_reg(3'(4*c+2), 32'h8000_0000 | 32'(len));
  endtask

  task automatic wait_done(input logic [1:0] m);
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(3, d);
      if ((d[1:0] & m) == m) break;
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #2;
    // R11 reset state
    chk("R11 retry", 32'(slv_retry), 0);
    chk("R11 hold", 32'(in_hold), 0);
    chk("R11 rq_valid", 32'(rq_valid), 0);
    chk("R11 irq", 32'(irq), 0);
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), d);
      chk("R11 reg", d, 0);
    end

    // R1: length without run flag starts nothing
    setup(0, 16'h1000, 16'h4000, 5);
    wr_reg(2, 32'd5);
    repeat (12) @(negedge clk);
    chk("R1 no start", 32'(nseq), 0);
    rd_reg(2, d);
    chk("R1 idle length", d, 32'd5);

    wr_reg(3, 32'h0000_000C);  // both interrupt enables (R9 bits 3:2)

    // R4 R5 R8 R9 sweep over lengths
    for (int len = 0; len < 20; len++) begin
      logic [15:0] sb, db;
      sb = 16'h1000 + 16'(len * 64);
      db = 16'h4000 + 16'(len * 64);
      setup(0, sb, db, len);
      falls = 0; stream_err = 0; nseq = 0;
      arm(0, len);
      wait_done(2'b01);
      repeat (3) @(negedge clk);
      chk("R4 word count", 32'(nwr[0]), 32'(len));
      chk("R4 stream", 32'(stream_err), 0);
      rd_reg(0, d); chk("R5 src", d, 32'(sb) + 32'(len));
      rd_reg(1, d); chk("R5 dst", d, 32'(db) + 32'(len));
      rd_reg(2, d); chk("R8 run cleared", d, 0);
      rd_reg(3, d); chk("R8 done", d, 32'h0000_000D);
      chk("R9 irq set", 32'(irq), 1);
      chk("R8 bridge use", 32'(falls), (len == 0) ? 0 : 1);
      wr_reg(3, 32'h0000_000D);
      repeat (3) @(negedge clk);
      rd_reg(3, d); chk("R9 w1c", d, 32'h0000_000C);
      chk("R9 irq clear", 32'(irq), 0);
    end

    // R9 with interrupt disabled
    wr_reg(3, 32'h0);
    setup(0, 16'h1100, 16'h4100, 5);
    arm(0, 5);
    wait_done(2'b01);
    repeat (3) @(negedge clk);
    chk("R9 masked irq", 32'(irq), 0);
    wr_reg(3, 32'h0000_000D);

    // R2 R3 acquisition order
    out_pending = 1; in_pending = 1; nseq = 0; stream_err = 0;
    setup(0, 16'h1200, 16'h4200, 4);
    arm(0, 4);
    repeat (6) @(negedge clk);
    chk("R2 retry", 32'(slv_retry), 1);
    chk("R2 no hold", 32'(in_hold), 0);
    chk("R2 no request", 32'(nseq), 0);
    out_pending = 0;
    repeat (5) @(negedge clk);
    chk("R3 hold", 32'(in_hold), 1);
    chk("R3 no request", 32'(nseq), 0);
    in_pending = 0;
    wait_done(2'b01);
    repeat (3) @(negedge clk);
    chk("R3 words", 32'(nwr[0]), 4);
    wr_reg(3, 32'h0000_000D);

    // R10 writes while running ignored
    rq_gate = 0;
    setup(0, 16'h1300, 16'h4300, 16);
    arm(0, 16);
    repeat (6) @(negedge clk);
    wr_reg(0, 32'h0000_1AAA);
    wr_reg(2, 32'h8000_0003);
    rd_reg(0, d); chk("R10 src kept", d, 32'h0000_1300);
    rd_reg(2, d); chk("R10 len kept", d, 32'h8000_0010);
    rq_gate = 1; stream_err = 0;
    wait_done(2'b01);
    repeat (3) @(negedge clk);
    chk("R10 words", 32'(nwr[0]), 16);
    chk("R10 stream", 32'(stream_err), 0);
    wr_reg(3, 32'h0000_000D);

    // R6 foreign access releases the bridge, once per source
    for (int k = 0; k < 2; k++) begin
      setup(0, 16'h1400, 16'h4400, 32);
      falls = 0; stream_err = 0;
      arm(0, 32);
      while (nwr[0] < 2) @(negedge clk);
      if (k == 0) in_req = 1; else slv_req = 1;
      @(negedge clk);
      in_req = 0; slv_req = 0;
      wait_done(2'b01);
      repeat (3) @(negedge clk);
      chk("R6 release count", 32'(falls), 2);
      chk("R6 words", 32'(nwr[0]), 32);
      chk("R6 stream", 32'(stream_err), 0);
      wr_reg(3, 32'h0000_000D);
    end

    // R7 alternation after reset
    pulse_reset();
    setup(0, 16'h1500, 16'h4500, 24);
    setup(1, 16'h2500, 16'h8500, 20);
    nseq = 0; falls = 0; stream_err = 0;
    arm(0, 24);
    arm(1, 20);
    wait_done(2'b11);
    repeat (3) @(negedge clk);
    chk("R7 bursts", 32'(nseq), 6);
    for (int i = 0; i < 6; i++) chk("R7 order", 32'(seq[i]), 32'(i % 2));
    chk("R7 ch0 words", 32'(nwr[0]), 24);
    chk("R7 ch1 words", 32'(nwr[1]), 20);
    chk("R7 stream", 32'(stream_err), 0);
    chk("R6 release per burst", 32'(falls), 6);
    rd_reg(3, d); chk("R8 both done", d, 32'h0000_0003);

    summary();
    $finish;
  end
endmodule